// File: doc/BRIEF.md
# SCSI Host Interrupt and Status Register Block

This block holds the status, interrupt-reason, sequence-step, flags, transfer-count and configuration registers of a simple SCSI host controller, and drives one level-sensitive interrupt line. Software uses a byte-wide register port. A write to the command register runs one of a small set of housekeeping commands: no-op, flush, chip reset, bus reset, enable selection, disable selection, message accepted, pad and initiator complete. Each command loads its own fixed pattern into the registers.

A sequencer outside this block does selection, bus phases and data movement. It reports each result over a valid/ready event channel. An event carries the status, reason and step values to load, plus a flag that asks for an interrupt. The block lowers `evt_ready` in any cycle with a register access. The sequencer must then hold `evt_valid` and its payload until a cycle where `evt_ready` is high. Reading the reason register is destructive. The read returns the old value, and in the same access it clears the reason register and the terminal-count flag, forces the step to command-done and drops the interrupt.

Register addresses: 0/1/2 transfer count low/mid/high, 3 command, 4 status, 5 reason, 6 step, 7 flags, 8 config. Status bit 7 is the interrupt flag and bit 4 is terminal count. Reason codes: 0x08 function complete, 0x10 bus service, 0x20 disconnect, 0x80 bus reset. Step value 4 means command done.

Top module: `scsi_irq_regs`

## Requirements
- R1: `irq` rises only when an interrupt request arrives while status bit 7 is clear. A request while the bit is already set changes nothing, so one reason read then clears it.
- R2: A read of address 5 returns the old reason value. After that access the reason reads 0, status bits 7 and 4 are clear, the step reads 4 and `irq` is low.
- R3: A write to address 0, 1 or 2 clears status bit 4.
- R4: Flush (0x01) sets the reason to 0x08, sets the step and flags to 0, and requests no interrupt.
- R5: Bus reset (0x03) sets the reason to 0x80. It raises the interrupt only when config bit 6 is clear.
- R6: Message accepted (0x12) sets the reason to 0x20, sets the step and flags to 0, and raises the interrupt.
- R7: Pad (0x18) sets the status to exactly 0x10, sets the reason to 0x08 and the step to 0, and leaves `irq` low.
- R8: Enable selection (0x44) clears the reason without an interrupt. Disable selection (0x45) clears the reason and raises the interrupt.
- R9: Reset and chip reset (0x02) zero every register, with two exceptions: transfer-count high reads `CHIP_ID` and config reads 7. `irq` ends low.
- R10: Initiator complete raises the interrupt and sets the reason to 0x08. Without bit 7 (0x11) it ORs 0x87 into the status and sets the flags to 2. With bit 7 (0x91) the status becomes 0x97 and the step 4.
- R11: Any command with bit 7 set copies the written count bytes into the readable count registers. Unknown opcodes and no-op change nothing else. Writes to addresses 4 to 7 are ignored.
- R12: `evt_ready` is low during a register access. An accepted event loads status bits 6:0, the reason and the step, and sets status bit 7 when `evt_raise` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state |
| evt_valid | input | 1 | Sequencer event valid |
| evt_ready | output | 1 | Event accepted this cycle when high with valid |
| evt_status | input | 7 | Status bits 6:0 to load |
| evt_reason | input | 8 | Reason value to load |
| evt_step | input | STEP_W | Step value to load |
| evt_raise | input | 1 | Request the interrupt |
| irq | output | 1 | Level interrupt, equal to status bit 7 |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that an event is presented only when no register access is under way, because an access holds `evt_ready` low. The stimulus drives one access per task call with an idle cycle between calls, and it presents events only in idle cycles. Each effect therefore lands on a single known clock edge. Every command is issued from a state where the bits it should change differ from the bits it leaves alone.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_INITCC,
    OP_MSGOK, OP_PAD, OP_SELON, OP_SELOFF, OP_UNKNOWN
  } op_e;

  localparam int ST_INT = 7;
  localparam int ST_TC  = 4;

  localparam logic [7:0] RSN_FC  = 8'h08;
  localparam logic [7:0] RSN_DC  = 8'h20;
  localparam logic [7:0] RSN_RST = 8'h80;

  localparam logic [6:0] CODE_NOP     = 7'h00;
  localparam logic [6:0] CODE_FLUSH   = 7'h01;
  localparam logic [6:0] CODE_CHIPRST = 7'h02;
  localparam logic [6:0] CODE_BUSRST  = 7'h03;
  localparam logic [6:0] CODE_INITCC  = 7'h11;
  localparam logic [6:0] CODE_MSGOK   = 7'h12;
  localparam logic [6:0] CODE_PAD     = 7'h18;
  localparam logic [6:0] CODE_SELON   = 7'h44;
  localparam logic [6:0] CODE_SELOFF  = 7'h45;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_irq_pkg::*;
(
  input  logic       fire_in,
  input  logic [7:0] code,
  output logic       cmd_fire,
  output op_e        op,
  output logic       is_dma
);
  assign cmd_fire = fire_in;
  assign is_dma   = code[7];

  always_comb begin
    unique case (code[6:0])
      CODE_NOP:     op = OP_NOP;
      CODE_FLUSH:   op = OP_FLUSH;
      CODE_CHIPRST: op = OP_CHIPRST;
      CODE_BUSRST:  op = OP_BUSRST;
      CODE_INITCC:  op = OP_INITCC;
      CODE_MSGOK:   op = OP_MSGOK;
      CODE_PAD:     op = OP_PAD;
      CODE_SELON:   op = OP_SELON;
      CODE_SELOFF:  op = OP_SELOFF;
      default:      op = OP_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/scsi_count_regs.sv
module scsi_count_regs #(
  parameter int ADDR_W      = 4,
  parameter int COUNT_BYTES = 3,
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wdata,
  input  logic                         reload,
  output logic [COUNT_BYTES-1:0][7:0]  count_rd,
  output logic                         count_wr
);
  localparam int TOP = COUNT_BYTES - 1;
  logic [COUNT_BYTES-1:0] hit;

  for (genvar i = 0; i < COUNT_BYTES; i++) begin : g_byte
    localparam logic [7:0] INIT = (i == TOP) ? CHIP_ID : 8'h00;
    logic [7:0] shadow;
    assign hit[i] = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow      <= 8'h00;
        count_rd[i] <= INIT;
      end else if (soft_rst) begin
        shadow      <= 8'h00;
        count_rd[i] <= INIT;
      end else begin
        if (hit[i]) shadow <= wdata;
        if (reload) count_rd[i] <= shadow;
      end
    end
  end

  assign count_wr = |hit;
endmodule

// File: rtl/scsi_status_core.sv
module scsi_status_core
  import scsi_irq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  op_e               op,
  input  logic              is_dma,
  input  logic              rd_reason,
  input  logic              count_wr,
  input  logic              rep_off,
  input  logic              evt_fire,
  input  logic [6:0]        evt_status,
  input  logic [7:0]        evt_reason,
  input  logic [STEP_W-1:0] evt_step,
  input  logic              evt_raise,
  output logic [7:0]        status,
  output logic [7:0]        reason,
  output logic [STEP_W-1:0] step,
  output logic [7:0]        flags
);
  localparam logic [STEP_W-1:0] STEP_DONE = STEP_W'(4);

  logic [7:0]        st_n, rs_n, fl_n;
  logic [STEP_W-1:0] sp_n;
  logic              raise;

  always_comb begin
    st_n = status; rs_n = reason; sp_n = step; fl_n = flags; raise = 1'b0;
    if (evt_fire) begin
      st_n[6:0] = evt_status;
      rs_n      = evt_reason;
      sp_n      = evt_step;
      raise     = evt_raise;
    end
    if (cmd_fire) begin
      unique case (op)
        OP_FLUSH:   begin rs_n = RSN_FC; sp_n = '0; fl_n = '0; end
        OP_CHIPRST: begin st_n = '0; rs_n = '0; sp_n = '0; fl_n = '0; end
        OP_BUSRST:  begin rs_n = RSN_RST; raise = !rep_off; end
        OP_MSGOK:   begin rs_n = RSN_DC; sp_n = '0; fl_n = '0; raise = 1'b1; end
        OP_PAD:     begin st_n = 8'h10; rs_n = RSN_FC; sp_n = '0; end
        OP_SELON:   rs_n = '0;
        OP_SELOFF:  begin rs_n = '0; raise = 1'b1; end
        OP_INITCC: begin
          if (is_dma) begin
            st_n = (status & 8'h80) | 8'h17;
            sp_n = STEP_DONE;
          end else begin
            st_n = status | 8'h07;
            fl_n = 8'h02;
          end
          rs_n  = RSN_FC;
          raise = 1'b1;
        end
        default: ;
      endcase
    end
    if (count_wr) st_n[ST_TC] = 1'b0;
    if (rd_reason) begin
      rs_n = '0;
      sp_n = STEP_DONE;
      st_n[ST_TC]  = 1'b0;
      st_n[ST_INT] = 1'b0;
    end
    if (raise) st_n[ST_INT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0; reason <= '0; step <= '0; flags <= '0;
    end else begin
      status <= st_n; reason <= rs_n; step <= sp_n; flags <= fl_n;
    end
  end

  // The interrupt flag only rises after a command or event that asks for it
  assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_INT]) |-> $past((evt_fire && evt_raise) ||
      (cmd_fire && (op == OP_BUSRST || op == OP_MSGOK ||
                    op == OP_SELOFF || op == OP_INITCC))));

  assert_reason_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reason && !cmd_fire && !count_wr && !evt_fire) |=>
      (reason == 8'h00 && step == STEP_DONE && !status[ST_INT] && !status[ST_TC]));

  assert_count_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && !evt_fire) |=> !status[ST_TC]);

  assert_flush_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_FLUSH && !status[ST_INT] && !evt_fire) |=>
      (!status[ST_INT] && reason == RSN_FC && flags == 8'h00));

  assert_busrst_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_BUSRST && rep_off && !status[ST_INT] && !evt_fire) |=>
      !status[ST_INT]);

  assert_pad_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_PAD && !evt_fire) |=> (status == 8'h10));
endmodule

// File: rtl/scsi_irq_regs.sv
module scsi_irq_regs
  import scsi_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STEP_W      = 3,
  parameter int COUNT_BYTES = 3,
  parameter logic [7:0] CHIP_ID   = 8'hA2,
  parameter logic [7:0] CFG_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [6:0]        evt_status,
  input  logic [7:0]        evt_reason,
  input  logic [STEP_W-1:0] evt_step,
  input  logic              evt_raise,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(COUNT_BYTES);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(COUNT_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_REASON = ADDR_W'(COUNT_BYTES + 2);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(COUNT_BYTES + 3);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(COUNT_BYTES + 4);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(COUNT_BYTES + 5);

  logic        cmd_fire, is_dma, count_wr, soft_rst, evt_fire, rd_reason;
  op_e         op;
  logic [7:0]  status, reason, flags, cfg, cmd_q;
  logic [STEP_W-1:0] step;
  logic [COUNT_BYTES-1:0][7:0] count_rd;

  assign evt_ready = !(reg_wr || reg_rd);
  assign evt_fire  = evt_valid && evt_ready;
  assign rd_reason = reg_rd && (reg_addr == A_REASON);
  assign soft_rst  = cmd_fire && (op == OP_CHIPRST);

  scsi_cmd_decode u_dec (
    .fire_in (reg_wr && (reg_addr == A_CMD)),
    .code    (reg_wdata),
    .cmd_fire(cmd_fire),
    .op      (op),
    .is_dma  (is_dma)
  );

  scsi_count_regs #(.ADDR_W(ADDR_W), .COUNT_BYTES(COUNT_BYTES), .CHIP_ID(CHIP_ID)) u_cnt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .reload(cmd_fire && is_dma && !soft_rst),
    .count_rd(count_rd), .count_wr(count_wr)
  );

  scsi_status_core #(.STEP_W(STEP_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .cmd_fire(cmd_fire), .op(op), .is_dma(is_dma),
    .rd_reason(rd_reason), .count_wr(count_wr), .rep_off(cfg[6]),
    .evt_fire(evt_fire), .evt_status(evt_status), .evt_reason(evt_reason),
    .evt_step(evt_step), .evt_raise(evt_raise),
    .status(status), .reason(reason), .step(step), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= CFG_RESET;
      cmd_q <= 8'h00;
    end else if (soft_rst) begin
      cfg   <= CFG_RESET;
      cmd_q <= 8'h00;
    end else begin
      if (reg_wr && reg_addr == A_CFG) cfg <= reg_wdata;
      if (cmd_fire) cmd_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < COUNT_BYTES; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = count_rd[i];
    unique case (reg_addr)
      A_CMD:    reg_rdata = cmd_q;
      A_STATUS: reg_rdata = status;
      A_REASON: reg_rdata = reason;
      A_STEP:   reg_rdata = 8'(step);
      A_FLAGS:  reg_rdata = flags;
      A_CFG:    reg_rdata = cfg;
      default: ;
    endcase
  end

  assign irq = status[ST_INT];
endmodule

// File: tb/scsi_irq_regs_test.sv
module scsi_irq_regs_test;
  localparam logic [7:0] CHIP = 8'hA2;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t q[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic evt_valid = 1'b0, evt_ready, evt_raise = 1'b0, irq;
  logic [6:0] evt_status = '0;
  logic [7:0] evt_reason = '0;
  logic [2:0] evt_step = '0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  scsi_irq_regs #(.CHIP_ID(CHIP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_status(evt_status),
    .evt_reason(evt_reason), .evt_step(evt_step), .evt_raise(evt_raise),
    .irq(irq)
  );

  // Monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    if (reg_rd) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (reg_rdata !== e.v) begin
        errors++;
        $display("FAIL %s: read addr %0d got %h expected %h", e.tag, reg_addr, reg_rdata, e.v);
      end
      checks++;
      if (evt_ready !== 1'b0) begin
        errors++;
        $display("FAIL R12: evt_ready got %b expected 0 during access", evt_ready);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    @(posedge clk); #1 q.push_back(x); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic evt(input logic [6:0] s, input logic [7:0] r, input logic [2:0] p, input logic up);
    @(posedge clk); #1 evt_valid = 1'b1; evt_status = s; evt_reason = r; evt_step = p; evt_raise = up;
    @(posedge clk); #1 evt_valid = 1'b0; evt_raise = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    chk_irq(1'b0, "R9");
    rd(4, 8'h00, "R9"); rd(5, 8'h00, "R9"); rd(2, CHIP, "R9");
    rd(8, 8'h07, "R9"); rd(0, 8'h00, "R9");
    // R12 / R1 event with raise, then a second raise while set
    evt(7'h10, 8'h18, 3'd4, 1'b1);
    chk_irq(1'b1, "R12");
    rd(4, 8'h90, "R12"); rd(6, 8'h04, "R12");
    evt(7'h10, 8'h18, 3'd4, 1'b1);
    chk_irq(1'b1, "R1");
    rd(5, 8'h18, "R2");
    chk_irq(1'b0, "R1");
    rd(4, 8'h00, "R2"); rd(6, 8'h04, "R2");
    // R3 count write clears terminal count
    evt(7'h10, 8'h10, 3'd2, 1'b0);
    chk_irq(1'b0, "R12");
    rd(4, 8'h10, "R12");
    wr(1, 8'h55);
    rd(4, 8'h00, "R3");
    // R10 initiator complete, programmed-I/O form
    wr(3, 8'h11);
    chk_irq(1'b1, "R10");
    rd(4, 8'h87, "R10"); rd(7, 8'h02, "R10"); rd(5, 8'h08, "R10");
    // R4 flush
    wr(3, 8'h01);
    chk_irq(1'b0, "R4");
    rd(6, 8'h00, "R4"); rd(7, 8'h00, "R4"); rd(5, 8'h08, "R4");
    // R5 bus reset, reporting on then off
    wr(3, 8'h03);
    chk_irq(1'b1, "R5");
    rd(5, 8'h80, "R5");
    wr(8, 8'h47);
    wr(3, 8'h03);
    chk_irq(1'b0, "R5");
    rd(5, 8'h80, "R5");
    // R6 message accepted
    wr(3, 8'h12);
    chk_irq(1'b1, "R6");
    rd(6, 8'h00, "R6"); rd(7, 8'h00, "R6"); rd(5, 8'h20, "R6");
    // R7 pad
    wr(3, 8'h18);
    chk_irq(1'b0, "R7");
    rd(4, 8'h10, "R7"); rd(6, 8'h00, "R7"); rd(5, 8'h08, "R7");
    // R8 selection enable / disable
    evt(7'h00, 8'h10, 3'd1, 1'b0);
    wr(3, 8'h44);
    chk_irq(1'b0, "R8");
    rd(5, 8'h00, "R8");
    evt(7'h00, 8'h10, 3'd1, 1'b0);
    wr(3, 8'h45);
    chk_irq(1'b1, "R8");
    rd(5, 8'h00, "R8");
    // R11 unknown opcode and ignored register writes
    evt(7'h00, 8'h18, 3'd3, 1'b0);
    wr(3, 8'h7F);
    chk_irq(1'b0, "R11");
    rd(6, 8'h03, "R11");
    wr(4, 8'hFF); wr(6, 8'h07);
    rd(4, 8'h00, "R11"); rd(6, 8'h03, "R11");
    // R10 initiator complete, DMA form (also reloads counts, R11)
    wr(3, 8'h91);
    chk_irq(1'b1, "R10");
    rd(4, 8'h97, "R10"); rd(6, 8'h04, "R10");
    rd(1, 8'h55, "R11"); rd(2, 8'h00, "R11");
    // R9 chip reset command
    wr(3, 8'h02);
    chk_irq(1'b0, "R9");
    rd(2, CHIP, "R9"); rd(8, 8'h07, "R9"); rd(1, 8'h00, "R9"); rd(3, 8'h00, "R9");
    // R11 DMA reload of counts
    wr(0, 8'h34); wr(2, 8'h12);
    rd(0, 8'h00, "R11");
    wr(3, 8'h80);
    rd(0, 8'h34, "R11"); rd(2, 8'h12, "R11");
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule